// File: doc/BRIEF.md
# Bus Clock Source Selector with Safe Fallback

This block picks the source of the bus clock: the PLL output or the external oscillator clock. Software asks for the oscillator by clearing a select bit. That request is taken only while the oscillator is qualified. If the oscillator stops being qualified while it drives the bus, the block sets the select bit again on its own, and the bus goes back to the PLL. Oscillator qualification is never true without PLL lock. Loss of lock therefore also removes oscillator qualification.

Two status bits are provided: lock and oscillator-qualified. Each has a sticky change flag that software clears by writing a one. An interrupt request is raised for any flag whose enable is set. While the PLL is unlocked, the post-divider setting shows the fixed fallback ratio of four. The programmed ratio returns once lock comes back. The clock multiplexer itself is modelled as two source-enable outputs. These are driven by a break-before-make sequence: the old source is dropped, a fixed gap passes, then the new source is raised. Bringing up the oscillator, then waiting for both status bits, then clearing the flags and finally writing the select bit is the intended order for software.

Top module: `bus_clk_selector`

## Requirements
- R1: After synchronous reset the select bit is 1, the PLL source enable is 1, the oscillator source enable is 0, both status bits are 0, the flags are 0, the interrupt request is 0 and the post-divider output is 4.
- R2: The lock status (`lock_sts`) follows `pll_lock_raw` one cycle later. The oscillator-qualified status (`osc_qual_sts`) is 1 one cycle after `pll_lock_raw`, `osc_en` and `osc_ok_raw` are all 1. It is 0 if any of them is 0.
- R3: `flags[0]` is set by any change of `lock_sts`, and `flags[1]` by any change of `osc_qual_sts`. Each flag is set in the same cycle as the status change it records.
- R4: Writing 1 to a bit of `flag_clr` clears that flag on the next cycle. If a status change and its clear fall in the same cycle, the flag ends up set.
- R5: `irq` equals the OR over all bits of `flags & irq_en`, and is aligned with the flags.
- R6: A select write (`sel_we`) with `sel_wdata`=1 sets the select bit on the next cycle. A write of 0 clears it on the next cycle only if `osc_qual_sts` is 1; otherwise the write is ignored.
- R7: If the select bit is 0 and `osc_qual_sts` is 0, the hardware sets the select bit on the next cycle.
- R8: `post_div` equals `pll_div_cfg` one cycle after `lock_sts` is 1. It equals FALLBACK_DIV (default 4) one cycle after `lock_sts` is 0.
- R9: A source change first drops the active source enable. Both enables then stay 0 for SYNC_CYC cycles (default 2), and after that the new source enable rises. The two enables are never 1 together.
- R10: The switch starts one cycle after the select bit changes. Select 1 maps to the PLL enable (`src_pll_en`), and select 0 maps to the oscillator enable (`src_osc_en`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we | input | 1 | Select bit write strobe |
| sel_wdata | input | 1 | Select bit write value (1 = PLL) |
| osc_en | input | 1 | Oscillator enable |
| pll_lock_raw | input | 1 | Raw PLL lock indication |
| osc_ok_raw | input | 1 | Raw oscillator-good indication |
| flag_clr | input | 2 | Write-one-to-clear strobes for the flags |
| irq_en | input | 2 | Interrupt enable per flag |
| pll_div_cfg | input | DIV_W | Programmed PLL post-divide ratio |
| sel_pll | output | 1 | Effective select bit (1 = PLL) |
| src_pll_en | output | 1 | PLL clock enable for the multiplexer |
| src_osc_en | output | 1 | Oscillator clock enable for the multiplexer |
| lock_sts | output | 1 | Registered lock status |
| osc_qual_sts | output | 1 | Registered oscillator-qualified status |
| flags | output | 2 | Change flags: bit 0 lock, bit 1 oscillator-qualified |
| irq | output | 1 | Interrupt request |
| post_div | output | DIV_W | Effective post-divide ratio |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a status change and a software clear of the matching flag. The bench drops PLL lock in the same cycle in which it writes ones to both clear bits. It expects both flags to be set, and the interrupt to be high, in the next cycle. The second pair is lock loss while the oscillator is selected. Here the same change that sets the flags also starts the hardware fallback of the select bit, the fallback divider and a full break-before-make sequence back to the PLL. Each of these is checked in the cycle worked out from the register stages.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int NFLAG = 2;
  localparam int FLG_LOCK = 0;
  localparam int FLG_OSCQ = 1;

  typedef enum logic [0:0] {
    SW_RUN = 1'b0,
    SW_GAP = 1'b1
  } sw_state_e;
endpackage

// File: rtl/bcs_status.sv
module bcs_status
  import bcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_en,
  input  logic             pll_lock_raw,
  input  logic             osc_ok_raw,
  input  logic [NFLAG-1:0] flag_clr,
  input  logic [NFLAG-1:0] irq_en,
  output logic             lock_sts,
  output logic             osc_qual_sts,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  logic             lock_n;
  logic             oscq_n;
  logic [NFLAG-1:0] chg;
  logic [NFLAG-1:0] flags_n;

  always_comb begin
    lock_n = pll_lock_raw;
    // qualification needs lock as well as a good, enabled oscillator
    oscq_n = pll_lock_raw & osc_en & osc_ok_raw;
    chg = '0;
    chg[FLG_LOCK] = lock_n ^ lock_sts;
    chg[FLG_OSCQ] = oscq_n ^ osc_qual_sts;
    // a new change wins over a clear in the same cycle
    flags_n = (flags & ~flag_clr) | chg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_sts     <= 1'b0;
      osc_qual_sts <= 1'b0;
      flags        <= '0;
      irq          <= 1'b0;
    end else begin
      lock_sts     <= lock_n;
      osc_qual_sts <= oscq_n;
      flags        <= flags_n;
      irq          <= |(flags_n & irq_en);
    end
  end
endmodule

// File: rtl/bcs_postdiv.sv
module bcs_postdiv #(
  parameter int DIV_W        = 3,
  parameter int FALLBACK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_sts,
  input  logic [DIV_W-1:0] pll_div_cfg,
  output logic [DIV_W-1:0] post_div
);
  localparam logic [DIV_W-1:0] FB = DIV_W'(FALLBACK_DIV);

  always_ff @(posedge clk) begin
    if (rst)           post_div <= FB;
    else if (lock_sts) post_div <= pll_div_cfg;
    else               post_div <= FB;
  end
endmodule

// File: rtl/bcs_switch.sv
module bcs_switch
  import bcs_pkg::*;
#(
  parameter int SYNC_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_pll,
  output logic src_pll_en,
  output logic src_osc_en
);
  localparam int CNT_W = (SYNC_CYC < 2) ? 1 : $clog2(SYNC_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_CYC - 1);

  sw_state_e        state;
  logic             cur_pll;
  logic             tgt_pll;
  logic [CNT_W-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SW_RUN;
      cur_pll    <= 1'b1;
      tgt_pll    <= 1'b1;
      gap_cnt    <= '0;
      src_pll_en <= 1'b1;
      src_osc_en <= 1'b0;
    end else begin
      case (state)
        SW_RUN: begin
          if (sel_pll != cur_pll) begin
            src_pll_en <= 1'b0;
            src_osc_en <= 1'b0;
            tgt_pll    <= sel_pll;
            gap_cnt    <= '0;
            state      <= SW_GAP;
          end
        end
        SW_GAP: begin
          if (gap_cnt == CNT_LAST) begin
            src_pll_en <= tgt_pll;
            src_osc_en <= ~tgt_pll;
            cur_pll    <= tgt_pll;
            state      <= SW_RUN;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= SW_RUN;
      endcase
    end
  end
endmodule

// File: rtl/bus_clk_selector.sv
module bus_clk_selector
  import bcs_pkg::*;
#(
  parameter int DIV_W        = 3,
  parameter int FALLBACK_DIV = 4,
  parameter int SYNC_CYC     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_we,
  input  logic             sel_wdata,
  input  logic             osc_en,
  input  logic             pll_lock_raw,
  input  logic             osc_ok_raw,
  input  logic [1:0]       flag_clr,
  input  logic [1:0]       irq_en,
  input  logic [DIV_W-1:0] pll_div_cfg,
  output logic             sel_pll,
  output logic             src_pll_en,
  output logic             src_osc_en,
  output logic             lock_sts,
  output logic             osc_qual_sts,
  output logic [1:0]       flags,
  output logic             irq,
  output logic [DIV_W-1:0] post_div
);
  bcs_status u_status (
    .clk          (clk),
    .rst          (rst),
    .osc_en       (osc_en),
    .pll_lock_raw (pll_lock_raw),
    .osc_ok_raw   (osc_ok_raw),
    .flag_clr     (flag_clr),
    .irq_en       (irq_en),
    .lock_sts     (lock_sts),
    .osc_qual_sts (osc_qual_sts),
    .flags        (flags),
    .irq          (irq)
  );

  // select bit: hardware fallback first, then gated software write
  always_ff @(posedge clk) begin
    if (rst)                         sel_pll <= 1'b1;
    else if (!sel_pll && !osc_qual_sts) sel_pll <= 1'b1;
    else if (sel_we && sel_wdata)    sel_pll <= 1'b1;
    else if (sel_we && osc_qual_sts) sel_pll <= 1'b0;
  end

  bcs_postdiv #(
    .DIV_W        (DIV_W),
    .FALLBACK_DIV (FALLBACK_DIV)
  ) u_postdiv (
    .clk         (clk),
    .rst         (rst),
    .lock_sts    (lock_sts),
    .pll_div_cfg (pll_div_cfg),
    .post_div    (post_div)
  );

  bcs_switch #(
    .SYNC_CYC (SYNC_CYC)
  ) u_switch (
    .clk        (clk),
    .rst        (rst),
    .sel_pll    (sel_pll),
    .src_pll_en (src_pll_en),
    .src_osc_en (src_osc_en)
  );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int DIV_W        = 3,
  parameter int FALLBACK_DIV = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_pll,
  input logic             src_pll_en,
  input logic             src_osc_en,
  input logic             lock_sts,
  input logic             osc_qual_sts,
  input logic [1:0]       flags,
  input logic [DIV_W-1:0] post_div
);
  assert_qual_needs_lock_R2: assert property (@(posedge clk) disable iff (rst)
    osc_qual_sts |-> lock_sts);

  assert_lock_change_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (lock_sts != $past(lock_sts)) |-> flags[0]);

  assert_fallback_sel_R7: assert property (@(posedge clk) disable iff (rst)
    (!sel_pll && !osc_qual_sts) |=> sel_pll);

  assert_unlock_div_R8: assert property (@(posedge clk) disable iff (rst)
    !lock_sts |=> (post_div == DIV_W'(FALLBACK_DIV)));

  assert_never_both_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({src_pll_en, src_osc_en}));

  assert_break_first_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(src_osc_en) |-> !$past(src_pll_en));
endmodule

bind bus_clk_selector bcs_checker #(
  .DIV_W        (DIV_W),
  .FALLBACK_DIV (FALLBACK_DIV)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sel_pll      (sel_pll),
  .src_pll_en   (src_pll_en),
  .src_osc_en   (src_osc_en),
  .lock_sts     (lock_sts),
  .osc_qual_sts (osc_qual_sts),
  .flags        (flags),
  .post_div     (post_div)
);

// File: tb/tb_bus_clk_selector.sv
module tb_bus_clk_selector;
  localparam int DIV_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_we = 1'b0, sel_wdata = 1'b0, osc_en = 1'b0;
  logic pll_lock_raw = 1'b0, osc_ok_raw = 1'b0;
  logic [1:0] flag_clr = '0, irq_en = '0;
  logic [DIV_W-1:0] pll_div_cfg = 3'd2;
  logic sel_pll, src_pll_en, src_osc_en, lock_sts, osc_qual_sts, irq;
  logic [1:0] flags;
  logic [DIV_W-1:0] post_div;

  always #10 clk = ~clk;

  bus_clk_selector dut (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .osc_en(osc_en), .pll_lock_raw(pll_lock_raw), .osc_ok_raw(osc_ok_raw),
    .flag_clr(flag_clr), .irq_en(irq_en), .pll_div_cfg(pll_div_cfg),
    .sel_pll(sel_pll), .src_pll_en(src_pll_en), .src_osc_en(src_osc_en),
    .lock_sts(lock_sts), .osc_qual_sts(osc_qual_sts), .flags(flags),
    .irq(irq), .post_div(post_div)
  );

  typedef struct {
    int       at;
    int       sig;
    int       val;
    string    req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int probe(int s);
    case (s)
      0: return int'(sel_pll);
      1: return int'(src_pll_en);
      2: return int'(src_osc_en);
      3: return int'(lock_sts);
      4: return int'(osc_qual_sts);
      5: return int'(flags);
      6: return int'(irq);
      default: return int'(post_div);
    endcase
  endfunction

  task automatic expect_at(int dly, int sig, int val, string req);
    exp_t e;
    e.at = cyc + dly; e.sig = sig; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compares all items due in this cycle, away from the clock edge
  always @(negedge clk) begin
    #1;
    foreach (q[i]) begin
      if (q[i].at == cyc) begin
        checks++;
        if (probe(q[i].sig) != q[i].val) begin
          errors++;
          $display("FAIL %s sig%0d actual %0d expected %0d (cycle %0d)",
                   q[i].req, q[i].sig, probe(q[i].sig), q[i].val, cyc);
        end
      end
    end
    q = q.find(e) with (e.at != cyc);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sel(bit v);
    sel_we = 1'b1; sel_wdata = v;
    @(negedge clk);
    sel_we = 1'b0; sel_wdata = 1'b0;
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    // R1 reset state
    expect_at(1, 0, 1, "R1"); expect_at(1, 1, 1, "R1");
    expect_at(1, 2, 0, "R1"); expect_at(1, 3, 0, "R1");
    expect_at(1, 4, 0, "R1"); expect_at(1, 5, 0, "R1");
    expect_at(1, 6, 0, "R1"); expect_at(1, 7, 4, "R1");
    step(3);

    // lock arrives: R2 status, R3 flag, R8 divider
    pll_lock_raw = 1'b1;
    expect_at(1, 3, 1, "R2"); expect_at(1, 5, 1, "R3");
    expect_at(1, 6, 0, "R5"); expect_at(2, 7, 2, "R8");
    step(3);

    // R6 write 0 ignored without oscillator qualification
    expect_at(1, 0, 1, "R6"); expect_at(3, 1, 1, "R6");
    pulse_sel(1'b0);
    step(3);

    // R5 enabling irq on a set flag
    irq_en = 2'b01;
    expect_at(1, 6, 1, "R5");
    step(2);

    // R4 clear
    flag_clr = 2'b01;
    expect_at(1, 5, 0, "R4"); expect_at(1, 6, 0, "R5");
    step(1); flag_clr = '0;
    step(2);

    // oscillator qualifies: R2, R3
    osc_en = 1'b1; osc_ok_raw = 1'b1;
    expect_at(1, 4, 1, "R2"); expect_at(1, 5, 2, "R3");
    expect_at(1, 6, 0, "R5");
    step(2);
    flag_clr = 2'b10;
    expect_at(1, 5, 0, "R4");
    step(1); flag_clr = '0;
    step(2);

    // switch to oscillator: R6, R10, R9
    expect_at(1, 0, 0, "R6");
    expect_at(2, 1, 0, "R10"); expect_at(2, 2, 0, "R9");
    expect_at(3, 2, 0, "R9"); expect_at(4, 2, 1, "R10");
    expect_at(4, 1, 0, "R9");
    pulse_sel(1'b0);
    step(6);

    // lock loss together with a clear of both flags: R4, R7, R8, R9
    irq_en = 2'b11;
    pll_lock_raw = 1'b0; flag_clr = 2'b11;
    expect_at(1, 5, 3, "R4"); expect_at(1, 3, 0, "R2");
    expect_at(1, 4, 0, "R2"); expect_at(1, 6, 1, "R5");
    expect_at(1, 0, 0, "R7"); expect_at(2, 0, 1, "R7");
    expect_at(2, 7, 4, "R8");
    expect_at(3, 2, 0, "R9"); expect_at(3, 1, 0, "R9");
    expect_at(4, 1, 0, "R9"); expect_at(5, 1, 1, "R10");
    step(1); flag_clr = '0;
    step(8);

    // lock returns, then oscillator disabled: R2
    pll_lock_raw = 1'b1;
    expect_at(1, 3, 1, "R2"); expect_at(1, 4, 1, "R2");
    expect_at(2, 7, 2, "R8");
    step(3);
    osc_en = 1'b0;
    expect_at(1, 4, 0, "R2"); expect_at(1, 3, 1, "R2");
    step(3);

    // back to oscillator, then software returns to PLL: R6
    osc_en = 1'b1;
    step(2);
    pulse_sel(1'b0);
    step(6);
    expect_at(1, 0, 1, "R6"); expect_at(5, 1, 1, "R10");
    expect_at(5, 2, 0, "R10");
    pulse_sel(1'b1);
    step(8);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule